// File: doc/BRIEF.md
# Serial Frame Parity Gate with Sticky Fault Flag

This block sits between a 16-bit serial receive shifter and the register write logic of a control interface. Each time the shifter signals that a full frame has arrived, the block checks whether the word has even parity across all sixteen bits. One bit of the word, D14, is set by the sender so that this holds. A frame that passes is marked accepted, and the register logic may commit it. A frame that fails is marked for discard, so none of its data reaches any register.

The block also keeps a fault flag. The serial output path places this flag into the word it shifts out during the next frame, whichever register is selected for readback. The flag is loaded only when a frame is strobed. A bad frame sets it, and a good frame clears it. After a run of bad frames it therefore stays set, and it returns to zero once a correctly formed frame has been received.

Top module: `fpc_parity_checker`

## Requirements
- R1: When `frame_valid_i` is 1 and `frame_i` holds an even number of 1 bits, with D14 (the parity bit) counted, `frame_accept_o` is 1 in the same cycle.
- R2: When `frame_valid_i` is 1 and `frame_i` holds an odd number of 1 bits, `frame_accept_o` is 0 in the same cycle, so the frame is discarded.
- R3: While `frame_valid_i` is 0, `frame_accept_o` is 0 whatever `frame_i` holds.
- R4: While `rst_ni` is low, and after reset until the first strobed frame, `parity_fault_o` is 0.
- R5: A strobed frame with odd parity makes `parity_fault_o` 1 from the next clock edge on, even if the following frame is good.
- R6: A strobed frame with even parity makes `parity_fault_o` 0 from the next clock edge on.
- R7: When several frames with odd parity arrive in a row, `parity_fault_o` stays 1 after each of them.
- R8: On a cycle with `frame_valid_i` at 0, `parity_fault_o` keeps its value at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_i | input | 16 | Received frame word, D15 down to D0 |
| frame_valid_i | input | 1 | One-cycle strobe: `frame_i` holds a complete frame |
| frame_accept_o | output | 1 | Commit permission for the register write logic |
| parity_fault_o | output | 1 | Sticky parity fault for the next readback word |

## Verification
The bench aims at three corner cases.

- **Two bad frames in a row, then a good one.** A design that cleared the flag on the second error, or kept it set after the good frame, would report the wrong fault state in the following readback.
- **Idle cycles with random data on the frame bus.** A design that let unstrobed data reach the flag or the accept output would corrupt the fault report, or commit data nobody sent.
- **Single-bit changes, including D14 alone.** A parity reduction that left out one bit position would accept corrupted frames.

Seeded random frames cover the remaining combinations.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
  localparam int unsigned FRAME_W = 16;
  localparam int unsigned PAR_POS = 14;
endpackage

// File: rtl/fpc_parity_tree.sv
module fpc_parity_tree #(
  parameter int unsigned WIDTH = 16
) (
  input  logic [WIDTH-1:0] word_i,
  output logic             odd_o
);
  logic [WIDTH:0] chain;
  assign chain[0] = 1'b0;

  for (genvar i = 0; i < WIDTH; i++) begin : g_xor
    assign chain[i+1] = chain[i] ^ word_i[i];
  end

  assign odd_o = chain[WIDTH];
endmodule

// File: rtl/fpc_fault_reg.sv
module fpc_fault_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic bad_i,
  output logic fault_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     fault_o <= 1'b0;
    else if (load_i) fault_o <= bad_i;
  end

  AST_FAULT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && bad_i && fault_o) |=> fault_o); // R7
  AST_FAULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(fault_o)); // R8
endmodule

// File: rtl/fpc_parity_checker.sv
module fpc_parity_checker
  import fpc_pkg::*;
#(
  parameter int unsigned WIDTH = FRAME_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] frame_i,
  input  logic             frame_valid_i,
  output logic             frame_accept_o,
  output logic             parity_fault_o
);
  logic odd_w;

  fpc_parity_tree #(.WIDTH(WIDTH)) u_tree (
    .word_i (frame_i),
    .odd_o  (odd_w)
  );

  // discard on odd parity; parity bit sits inside the word
  assign frame_accept_o = frame_valid_i & ~odd_w;

  fpc_fault_reg u_fault (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (frame_valid_i),
    .bad_i   (odd_w),
    .fault_o (parity_fault_o)
  );

  AST_ACCEPT_EVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_valid_i |-> (frame_accept_o == ($countones(frame_i) % 2 == 0))); // R1
  AST_IDLE_NO_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_valid_i |-> !frame_accept_o); // R3
  AST_BAD_SETS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_valid_i && !frame_accept_o) |=> parity_fault_o); // R5
  AST_GOOD_CLEARS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_accept_o |=> !parity_fault_o); // R6
endmodule

// File: tb/tb_fpc_parity_checker.sv
module tb_fpc_parity_checker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] frame = '0;
  logic        valid = 1'b0;
  logic        accept, fault;
  int          n_chk = 0;
  int          n_bad = 0;
  logic        exp_fault = 1'b0;

  always #4 clk = ~clk;

  fpc_parity_checker dut (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .frame_i        (frame),
    .frame_valid_i  (valid),
    .frame_accept_o (accept),
    .parity_fault_o (fault)
  );

  function automatic logic is_even(input logic [15:0] w);
    int ones = 0;
    for (int i = 0; i < 16; i++) ones += w[i];
    return (ones % 2) == 0;
  endfunction

  function automatic logic [15:0] fix_parity(input logic [15:0] w, input logic want_even);
    logic [15:0] r = w;
    if (is_even(r) != want_even) r[14] = ~r[14];
    return r;
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // drive at negedge; accept is checked in the same cycle, flag after the edge
  task automatic send(input logic [15:0] w);
    @(negedge clk);
    frame = w;
    valid = 1'b1;
    #1;
    check(is_even(w) ? "R1" : "R2", accept, is_even(w));
    @(negedge clk);
    valid = 1'b0;
    exp_fault = !is_even(w);
    check(is_even(w) ? "R6" : "R5", fault, exp_fault);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      frame = 16'($urandom);
      valid = 1'b0;
      #1;
      check("R3", accept, 1'b0);
      @(posedge clk);
      #1;
      check("R8", fault, exp_fault);
    end
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    n_chk++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    #3;
    check("R4", fault, 1'b0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R4", fault, 1'b0);
    idle(2);

    // directed cases
    send(16'h0000);
    send(16'h4000);                       // D14 alone: odd
    idle(3);
    send(16'h4001);                       // good, clears the flag
    send(fix_parity(16'h1234, 1'b0));     // R7: two bad frames in a row
    send(fix_parity(16'hbeef, 1'b0));
    check("R7", fault, 1'b1);
    idle(2);
    send(fix_parity(16'hbeef, 1'b1));
    send(16'hffff);
    send(16'h8000);
    for (int b = 0; b < 16; b++) send(16'(1) << b); // each bit alone: all odd
    send(16'h0003);

    // seeded random stream with idle gaps
    for (int i = 0; i < 300; i++) begin
      send(16'($urandom));
      if ($urandom_range(3) == 0) idle(int'($urandom_range(3)) + 1);
    end

    // reset while the flag is set
    send(16'h0001);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R4", fault, 1'b0);
    exp_fault = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    idle(1);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule